// File: doc/BRIEF.md
# Chip-Select Bus Cycle Timing Generator

This block times a single access to an external memory or peripheral on behalf of a simple chip-select memory controller. A one-cycle start request carries a direction (read or write) and a bank number. The block looks up that bank's timing options, copies them into working state, and then steps through four phases: setup, an optional lead, the strobe window and an optional write tail. It drives active-low chip-select, write-enable and output-enable strobes. When the access is over it raises a one-cycle done pulse. An external acknowledge input can end the strobe window early, or it can be the only thing that ends it.

The block runs on an internal clock four times the bus clock. This lets chip-select be placed a quarter or a half bus clock after the address. Every timing value is counted in internal clocks, with one bus clock equal to `QPB` internal clocks.

Each bank has an option word. Bit positions in the word:

| Bits | Field |
|---|---|
| [1:0] | setup code |
| [2] | extra-setup |
| [2+SCY_W:3] | wait-state count |
| [3+SCY_W] | external-end |
| [4+SCY_W] | relaxed |

Software loads these words through a simple write port. The strobes are registered, so every strobe edge shows up one internal clock after the phase change that causes it.

Top module: `cs_cycle_timer`

## Requirements

Counting convention: the clock edge that accepts a request is edge 0. A strobe "after edge n" is the value seen between edge n and edge n+1. D, L, S and T are measured in internal clocks.

- R1: After reset, cs_n, we_n and oe_n are high and done is low. Bank 0 resets to setup code 11, extra-setup 1, wait count all ones, external-end 0 and relaxed 0. All other banks reset to all zeros.
- R2: cs_n first goes low after edge D+1. D is the setup delay: QPB/4 for setup code 10, QPB/2 for code 11, and 0 for code 00. The extra-setup bit adds QPB to D.
- R3: Setup code 01 behaves exactly like code 00. This covers the setup delay, the lead phase and the chip-select level during the write tail.
- R4: The strobe window lasts S = QPB*(1+N) internal clocks, where N is the wait-state count. N is doubled in relaxed mode. The direction strobe rises after edge D+L+S+1.
- R5: The direction strobe falls after edge D+L+1. L = QPB when relaxed mode is on and the effective setup code is not 00; otherwise L = 0.
- R6: A relaxed write adds a tail of T = QPB clocks after the strobe window. we_n is high during the tail. cs_n rises together with we_n when the effective setup code is not 00; otherwise cs_n stays low until the end of the tail.
- R7: With external-end 0, ext_ack high at an edge inside the strobe window ends the window: strobes rise after the next edge. ext_ack during the setup phase is ignored.
- R8: With external-end 1, the wait counter cannot end the access. The window lasts until ext_ack is seen.
- R9: done is high for exactly one clock. That clock is after edge D+L+S+T+1, and all three strobes are high in it.
- R10: A read pulls only oe_n low and a write pulls only we_n low. oe_n and we_n are never low together.
- R11: A request that arrives while an access is running is ignored. An option write made during an access does not change that access.
- R12: Each access uses the option word of the bank it names at the accepting edge. A write replaces only the addressed bank's word.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, QPB times the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_we | input | 1 | Option word write strobe |
| opt_bank | input | BANK_W | Bank whose option word is written |
| opt_wdata | input | OPT_W | Option word to write |
| req | input | 1 | Start an access; sampled only when idle |
| req_wr | input | 1 | Access direction, 1 for write |
| req_bank | input | BANK_W | Bank whose options time the access |
| ext_ack | input | 1 | External acknowledge ending the strobe window |
| cs_n | output | 1 | Chip-select, active low |
| we_n | output | 1 | Write-enable, active low |
| oe_n | output | 1 | Output-enable, active low |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification

A counter loaded with the wrong value, or a phase taking the wrong branch, moves a strobe edge by a whole number of internal clocks within the same access. Measuring the clock on which each strobe changes therefore exposes it before done. A wrong branch out of the strobe window shows up on the next clock: either we_n rises without a tail, or done arrives QPB clocks late. A fault in option capture or bank selection shows as a wrong timing on the next access to that bank. An ignored acknowledge shows as strobes that stay low after ext_ack.

// File: rtl/cs_timing_pkg.sv
package cs_timing_pkg;

   // Phases of one access
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_LEAD   = 3'd2,
      PH_STROBE = 3'd3,
      PH_TAIL   = 3'd4,
      PH_DONE   = 3'd5
   } phase_t;

   // Address-to-chip-select setup encodings
   typedef enum logic [1:0] {
      SU_NONE = 2'b00,
      SU_RSVD = 2'b01,
      SU_QTR  = 2'b10,
      SU_HALF = 2'b11
   } setup_code_t;

   // The reserved code is folded onto the zero-delay code
   function automatic setup_code_t setup_effective(input logic [1:0] raw);
      setup_code_t code;
      code = setup_code_t'(raw);
      if (code == SU_RSVD) begin
         code = SU_NONE;
      end
      return code;
   endfunction

endpackage

// File: rtl/cs_opt_bank.sv
module cs_opt_bank #(
   parameter int NBANK  = 4,
   parameter int SCY_W  = 4,
   parameter int BANK_W = 2,
   parameter int OPT_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] wr_bank,
   input  logic [OPT_W-1:0]  wr_data,
   input  logic [BANK_W-1:0] rd_bank,
   output logic [OPT_W-1:0]  rd_data
);

   // Bank 0 boots into the slowest timing so any device can be reached
   localparam logic [OPT_W-1:0] BOOT0 = {1'b0, 1'b0, {SCY_W{1'b1}}, 1'b1, 2'b11};

   logic [OPT_W-1:0] regs [NBANK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NBANK; b++) begin
            regs[b] <= (b == 0) ? BOOT0 : '0;
         end
      end else begin
         for (int b = 0; b < NBANK; b++) begin
            if (wr_en && (int'(wr_bank) == b)) begin
               regs[b] <= wr_data;
            end
         end
      end
   end

   generate
      if ((1 << BANK_W) == NBANK) begin : g_pow2
         assign rd_data = regs[rd_bank];
      end else begin : g_guard
         assign rd_data = (int'(rd_bank) < NBANK) ? regs[rd_bank] : '0;
      end
   endgenerate

endmodule

// File: rtl/cs_delay_calc.sv
module cs_delay_calc
   import cs_timing_pkg::*;
#(
   parameter int QPB      = 4,
   parameter int SCY_W    = 4,
   parameter int CNT_W    = 7,
   parameter bit RELAX_EN = 1'b1
) (
   input  logic [1:0]       setup_raw,
   input  logic             xsetup,
   input  logic [SCY_W-1:0] scy,
   input  logic             relax,
   input  logic             is_write,
   output logic [CNT_W-1:0] setup_len,
   output logic [CNT_W-1:0] lead_len,
   output logic [CNT_W-1:0] strobe_len,
   output logic             tail_en,
   output logic             tail_cs_hold
);

   localparam logic [CNT_W-1:0] QTR_LEN  = CNT_W'(QPB / 4);
   localparam logic [CNT_W-1:0] HALF_LEN = CNT_W'(QPB / 2);
   localparam logic [CNT_W-1:0] BUS_LEN  = CNT_W'(QPB);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic             relax_eff;
   setup_code_t      su;
   logic [CNT_W-1:0] base_len;
   logic [CNT_W-1:0] waits;

   // Variant: relaxed timing may be compiled out entirely
   generate
      if (RELAX_EN) begin : g_relax
         assign relax_eff = relax;
      end else begin : g_norelax
         logic unused_relax;
         assign unused_relax = relax;
         assign relax_eff    = 1'b0;
      end
   endgenerate

   always_comb begin
      su = setup_effective(setup_raw);
      unique case (su)
         SU_QTR:  base_len = QTR_LEN;
         SU_HALF: base_len = HALF_LEN;
         default: base_len = '0;
      endcase
      setup_len    = base_len + (xsetup ? BUS_LEN : '0);
      lead_len     = (relax_eff && (su != SU_NONE)) ? BUS_LEN : '0;
      waits        = relax_eff ? CNT_W'({scy, 1'b0}) : CNT_W'(scy);
      strobe_len   = BUS_LEN * (waits + CNT_ONE);
      tail_en      = relax_eff & is_write;
      tail_cs_hold = (su == SU_NONE);
   end

endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
   import cs_timing_pkg::*;
#(
   parameter int QPB   = 4,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             req_wr,
   input  logic [CNT_W-1:0] setup_len,
   input  logic [CNT_W-1:0] lead_len,
   input  logic [CNT_W-1:0] strobe_len,
   input  logic             tail_en,
   input  logic             tail_cs_hold,
   input  logic             ext_end,
   input  logic             ack,
   output phase_t           phase,
   output logic             wr_q,
   output logic             cs_hold_q
);

   localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(QPB - 1);

   logic [CNT_W-1:0] cnt, cnt_n;
   logic [CNT_W-1:0] lead_q, strobe_q;
   logic             tail_q, ext_q;
   phase_t           ph_n;
   logic             cap;
   logic             win_end;

   assign win_end = ack || (!ext_q && (cnt == '0));

   always_comb begin
      ph_n  = phase;
      cnt_n = cnt;
      cap   = 1'b0;
      unique case (phase)
         PH_IDLE: begin
            if (req) begin
               cap = 1'b1;
               if (setup_len != '0) begin
                  ph_n  = PH_SETUP;
                  cnt_n = setup_len - CNT_ONE;
               end else if (lead_len != '0) begin
                  ph_n  = PH_LEAD;
                  cnt_n = lead_len - CNT_ONE;
               end else begin
                  ph_n  = PH_STROBE;
                  cnt_n = strobe_len - CNT_ONE;
               end
            end
         end
         PH_SETUP: begin
            if (cnt == '0) begin
               if (lead_q != '0) begin
                  ph_n  = PH_LEAD;
                  cnt_n = lead_q - CNT_ONE;
               end else begin
                  ph_n  = PH_STROBE;
                  cnt_n = strobe_q - CNT_ONE;
               end
            end else begin
               cnt_n = cnt - CNT_ONE;
            end
         end
         PH_LEAD: begin
            if (cnt == '0) begin
               ph_n  = PH_STROBE;
               cnt_n = strobe_q - CNT_ONE;
            end else begin
               cnt_n = cnt - CNT_ONE;
            end
         end
         PH_STROBE: begin
            if (win_end) begin
               if (tail_q) begin
                  ph_n  = PH_TAIL;
                  cnt_n = TAIL_LOAD;
               end else begin
                  ph_n  = PH_DONE;
               end
            end else if (cnt != '0) begin
               cnt_n = cnt - CNT_ONE;
            end
         end
         PH_TAIL: begin
            if (cnt == '0) begin
               ph_n = PH_DONE;
            end else begin
               cnt_n = cnt - CNT_ONE;
            end
         end
         PH_DONE: ph_n = PH_IDLE;
         default: ph_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         lead_q    <= '0;
         strobe_q  <= '0;
         tail_q    <= 1'b0;
         ext_q     <= 1'b0;
         wr_q      <= 1'b0;
         cs_hold_q <= 1'b0;
      end else begin
         phase <= ph_n;
         cnt   <= cnt_n;
         if (cap) begin
            lead_q    <= lead_len;
            strobe_q  <= strobe_len;
            tail_q    <= tail_en;
            ext_q     <= ext_end;
            wr_q      <= req_wr;
            cs_hold_q <= tail_cs_hold;
         end
      end
   end

   AST_EXT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STROBE && ext_q && !ack) |=> (phase == PH_STROBE)); // R8
   AST_ACK_ENDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STROBE && ack) |=> (phase == PH_TAIL || phase == PH_DONE)); // R7
   AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE) |=> (phase == PH_IDLE)); // R9
   AST_BUSY_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && req) |=> $stable(wr_q)); // R11

endmodule

// File: rtl/cs_strobe_out.sv
module cs_strobe_out
   import cs_timing_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  phase_t phase,
   input  logic   wr_q,
   input  logic   cs_hold_q,
   output logic   cs_n,
   output logic   we_n,
   output logic   oe_n,
   output logic   done
);

   logic cs_d, we_d, oe_d, done_d;

   always_comb begin
      cs_d   = (phase == PH_LEAD) || (phase == PH_STROBE) ||
               ((phase == PH_TAIL) && cs_hold_q);
      we_d   = (phase == PH_STROBE) && wr_q;
      oe_d   = (phase == PH_STROBE) && !wr_q;
      done_d = (phase == PH_DONE);
   end

   // Registered strobes: no decode glitches reach the pins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n <= 1'b1;
         we_n <= 1'b1;
         oe_n <= 1'b1;
         done <= 1'b0;
      end else begin
         cs_n <= !cs_d;
         we_n <= !we_d;
         oe_n <= !oe_d;
         done <= done_d;
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && we_n && oe_n)); // R9
   AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !oe_n)); // R10
   AST_CTRL_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || !oe_n) |-> !cs_n); // R5

endmodule

// File: rtl/cs_cycle_timer.sv
module cs_cycle_timer
   import cs_timing_pkg::*;
#(
   parameter int QPB      = 4,
   parameter int SCY_W    = 4,
   parameter int NBANK    = 4,
   parameter bit RELAX_EN = 1'b1,
   localparam int BANK_W  = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int OPT_W   = SCY_W + 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              opt_we,
   input  logic [BANK_W-1:0] opt_bank,
   input  logic [OPT_W-1:0]  opt_wdata,
   input  logic              req,
   input  logic              req_wr,
   input  logic [BANK_W-1:0] req_bank,
   input  logic              ext_ack,
   output logic              cs_n,
   output logic              we_n,
   output logic              oe_n,
   output logic              done
);

   localparam int MAX_WAIT = 2 * ((1 << SCY_W) - 1);
   localparam int MAX_CNT  = QPB * (MAX_WAIT + 1);
   localparam int CNT_W    = $clog2(MAX_CNT + 1);

   generate
      if (QPB < 4 || (QPB % 4) != 0) begin : g_bad_qpb
         $error("QPB must be a positive multiple of four");
      end
      if (SCY_W < 1 || NBANK < 1) begin : g_bad_size
         $error("SCY_W and NBANK must be at least one");
      end
   endgenerate

   logic [OPT_W-1:0] opt_sel;
   logic [1:0]       f_setup;
   logic             f_xsetup, f_ext, f_relax;
   logic [SCY_W-1:0] f_scy;
   logic [CNT_W-1:0] setup_len, lead_len, strobe_len;
   logic             tail_en, tail_cs_hold;
   phase_t           phase;
   logic             wr_q, cs_hold_q;

   cs_opt_bank #(
      .NBANK(NBANK), .SCY_W(SCY_W), .BANK_W(BANK_W), .OPT_W(OPT_W)
   ) u_opts (
      .clk(clk), .rst_n(rst_n), .wr_en(opt_we), .wr_bank(opt_bank),
      .wr_data(opt_wdata), .rd_bank(req_bank), .rd_data(opt_sel)
   );

   assign f_setup  = opt_sel[1:0];
   assign f_xsetup = opt_sel[2];
   assign f_scy    = opt_sel[2+SCY_W:3];
   assign f_ext    = opt_sel[3+SCY_W];
   assign f_relax  = opt_sel[4+SCY_W];

   cs_delay_calc #(
      .QPB(QPB), .SCY_W(SCY_W), .CNT_W(CNT_W), .RELAX_EN(RELAX_EN)
   ) u_calc (
      .setup_raw(f_setup), .xsetup(f_xsetup), .scy(f_scy), .relax(f_relax),
      .is_write(req_wr), .setup_len(setup_len), .lead_len(lead_len),
      .strobe_len(strobe_len), .tail_en(tail_en), .tail_cs_hold(tail_cs_hold)
   );

   cs_seq_fsm #(
      .QPB(QPB), .CNT_W(CNT_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
      .setup_len(setup_len), .lead_len(lead_len), .strobe_len(strobe_len),
      .tail_en(tail_en), .tail_cs_hold(tail_cs_hold), .ext_end(f_ext),
      .ack(ext_ack), .phase(phase), .wr_q(wr_q), .cs_hold_q(cs_hold_q)
   );

   cs_strobe_out u_out (
      .clk(clk), .rst_n(rst_n), .phase(phase), .wr_q(wr_q),
      .cs_hold_q(cs_hold_q), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
      .done(done)
   );

endmodule

// File: tb/tb_cs_cycle_timer.sv
module tb_cs_cycle_timer;

   localparam int OPT_W  = 9;
   localparam int BANK_W = 2;
   localparam int NV     = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic opt_we = 1'b0;
   logic [BANK_W-1:0] opt_bank = '0;
   logic [OPT_W-1:0]  opt_wdata = '0;
   logic req = 1'b0, req_wr = 1'b0, ext_ack = 1'b0;
   logic [BANK_W-1:0] req_bank = '0;
   logic cs_n, we_n, oe_n, done;

   int n_chk = 0, n_err = 0;
   bit finished = 1'b0;
   int m_cs_lo, m_cs_hi, m_ctl_lo, m_ctl_hi, m_done, m_done_len, m_bad;

   always #5 clk = ~clk;

   cs_cycle_timer dut (
      .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .opt_bank(opt_bank),
      .opt_wdata(opt_wdata), .req(req), .req_wr(req_wr), .req_bank(req_bank),
      .ext_ack(ext_ack), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .done(done)
   );

   // {wr, relax, setup[1:0], xs, scy[3:0], D[7:0], L[7:0], S[7:0], T[7:0], cs_early}
   localparam logic [41:0] VEC [NV] = '{
      {1'b0, 1'b0, 2'b00, 1'b0, 4'd0,  8'd0, 8'd0, 8'd4,  8'd0, 1'b0},
      {1'b1, 1'b0, 2'b10, 1'b0, 4'd3,  8'd1, 8'd0, 8'd16, 8'd0, 1'b0},
      {1'b0, 1'b0, 2'b11, 1'b0, 4'd1,  8'd2, 8'd0, 8'd8,  8'd0, 1'b0},
      {1'b1, 1'b0, 2'b01, 1'b1, 4'd2,  8'd4, 8'd0, 8'd12, 8'd0, 1'b0},
      {1'b0, 1'b1, 2'b10, 1'b0, 4'd2,  8'd1, 8'd4, 8'd20, 8'd0, 1'b0},
      {1'b1, 1'b1, 2'b11, 1'b1, 4'd1,  8'd6, 8'd4, 8'd12, 8'd4, 1'b1},
      {1'b1, 1'b1, 2'b00, 1'b0, 4'd1,  8'd0, 8'd0, 8'd12, 8'd4, 1'b0},
      {1'b1, 1'b1, 2'b01, 1'b0, 4'd0,  8'd0, 8'd0, 8'd4,  8'd4, 1'b0},
      {1'b0, 1'b1, 2'b01, 1'b1, 4'd3,  8'd4, 8'd0, 8'd28, 8'd0, 1'b0},
      {1'b0, 1'b0, 2'b00, 1'b1, 4'd15, 8'd4, 8'd0, 8'd64, 8'd0, 1'b0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [OPT_W-1:0] opt_word(input bit relax, input bit ext,
      input logic [3:0] scy, input bit xs, input logic [1:0] su);
      return {relax, ext, scy, xs, su};
   endfunction

   task automatic write_opt(input int bank, input logic [OPT_W-1:0] w);
      @(negedge clk);
      opt_we = 1'b1; opt_bank = BANK_W'(bank); opt_wdata = w;
      @(negedge clk);
      opt_we = 1'b0;
   endtask

   // Index k: values seen after edge k, edge 0 accepting the request
   task automatic run_acc(input int bank, input bit wr, input int ack_k,
      input int poke_k, input logic [OPT_W-1:0] poke_w);
      logic ctl, oth;
      @(negedge clk);
      req = 1'b1; req_wr = wr; req_bank = BANK_W'(bank);
      @(negedge clk);
      req = 1'b0;
      m_cs_lo = -1; m_cs_hi = -1; m_ctl_lo = -1; m_ctl_hi = -1;
      m_done = -1; m_done_len = 0; m_bad = 0;
      for (int k = 0; k < 400; k++) begin
         ctl = wr ? we_n : oe_n;
         oth = wr ? oe_n : we_n;
         if (!oth) m_bad++;
         if (!cs_n && m_cs_lo < 0) m_cs_lo = k;
         if (cs_n && m_cs_lo >= 0 && m_cs_hi < 0) m_cs_hi = k;
         if (!ctl && m_ctl_lo < 0) m_ctl_lo = k;
         if (ctl && m_ctl_lo >= 0 && m_ctl_hi < 0) m_ctl_hi = k;
         if (done) begin
            m_done = k;
            if (!(cs_n && we_n && oe_n)) m_bad++;
         end
         ext_ack = (k == ack_k);
         if (k == poke_k) begin
            req = 1'b1; opt_we = 1'b1; opt_bank = BANK_W'(bank); opt_wdata = poke_w;
         end else begin
            req = 1'b0; opt_we = 1'b0;
         end
         if (m_done >= 0) begin
            @(negedge clk);
            m_done_len = done ? 2 : 1;
            break;
         end
         @(negedge clk);
      end
      ext_ack = 1'b0; req = 1'b0; opt_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int d, l, s, t, idle_bad;
      bit early;
      repeat (3) @(negedge clk);
      chk("R1 reset cs_n", int'(cs_n), 1);
      chk("R1 reset we_n", int'(we_n), 1);
      chk("R1 reset oe_n", int'(oe_n), 1);
      chk("R1 reset done", int'(done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: bank 0 boot options D=6 L=0 S=64
      run_acc(0, 1'b0, -1, -1, '0);
      chk("R1 boot cs fall", m_cs_lo, 7);
      chk("R1 boot oe rise", m_ctl_hi, 71);
      chk("R1 boot done", m_done, 71);

      // Vector table: R2 R3 R4 R5 R6 R9 R10
      for (int i = 0; i < NV; i++) begin
         logic [41:0] v;
         v = VEC[i];
         d = int'(v[32:25]); l = int'(v[24:17]); s = int'(v[16:9]);
         t = int'(v[8:1]); early = v[0];
         write_opt(1 + (i % 3), opt_word(v[40], 1'b0, v[36:33], v[37], v[39:38]));
         run_acc(1 + (i % 3), v[41], -1, -1, '0);
         chk($sformatf("R2 R3 vec%0d cs fall", i), m_cs_lo, d + 1);
         chk($sformatf("R5 vec%0d ctrl fall", i), m_ctl_lo, d + l + 1);
         chk($sformatf("R4 vec%0d ctrl rise", i), m_ctl_hi, d + l + s + 1);
         chk($sformatf("R6 vec%0d cs rise", i), m_cs_hi,
             early ? d + l + s + 1 : d + l + s + t + 1);
         chk($sformatf("R9 vec%0d done time", i), m_done, d + l + s + t + 1);
         chk($sformatf("R9 vec%0d done width", i), m_done_len, 1);
         chk($sformatf("R10 vec%0d wrong strobe", i), m_bad, 0);
      end

      // R7: early acknowledge, D=0 S=64, ack seen at edge 11
      write_opt(1, opt_word(1'b0, 1'b0, 4'd15, 1'b0, 2'b00));
      run_acc(1, 1'b0, 10, -1, '0);
      chk("R7 ack ends window", m_ctl_hi, 12);
      chk("R7 ack done", m_done, 12);

      // R7: ack during setup ignored, D=6 S=8
      write_opt(1, opt_word(1'b0, 1'b0, 4'd1, 1'b1, 2'b11));
      run_acc(1, 1'b0, 2, -1, '0);
      chk("R7 setup ack ignored", m_ctl_hi, 15);

      // R8: external end only, counter would stop at 5
      write_opt(2, opt_word(1'b0, 1'b1, 4'd0, 1'b0, 2'b00));
      run_acc(2, 1'b1, 30, -1, '0);
      chk("R8 waits for ack", m_ctl_hi, 32);
      chk("R8 done", m_done, 32);

      // R12: bank independence
      write_opt(2, opt_word(1'b0, 1'b0, 4'd0, 1'b0, 2'b00));
      write_opt(3, opt_word(1'b0, 1'b0, 4'd5, 1'b1, 2'b11));
      run_acc(2, 1'b0, -1, -1, '0);
      chk("R12 bank2 cs fall", m_cs_lo, 1);
      chk("R12 bank2 oe rise", m_ctl_hi, 5);

      // R11: request and option write during access, D=1 S=32
      write_opt(1, opt_word(1'b0, 1'b0, 4'd7, 1'b0, 2'b10));
      run_acc(1, 1'b0, -1, 5, opt_word(1'b0, 1'b0, 4'd0, 1'b0, 2'b10));
      chk("R11 timing unchanged", m_ctl_hi, 34);
      idle_bad = 0;
      for (int j = 0; j < 8; j++) begin
         @(negedge clk);
         if (!cs_n || done) idle_bad++;
      end
      chk("R11 no restart", idle_bad, 0);
      run_acc(1, 1'b0, -1, -1, '0);
      chk("R12 new option used", m_ctl_hi, 6);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule